// File: doc/BRIEF.md
# ADC Conversion Start and Busy Sequencer

This block is the digital control core of a successive-approximation converter. A conversion can be requested by a rising edge on a hardware start pin or by a bus write with the start bit set. The request moves the sample-and-hold control to hold and raises busy at once. The block then lines the request up with a falling edge of the converter master clock. Busy is held for a fixed number of master-clock half-periods, and a one-cycle done strobe follows. The analog array, comparator and result register are not part of the block. A half-period counter stands in for them.

The block runs on a clock at twice the master-clock rate, so one system cycle equals one master-clock half-period. The master clock is generated internally and brought out as `masterClk`. A falling master-clock edge occurs at every system edge where `masterClk` is 1 just before that edge. The first start after reset runs a self-calibration, which is longer than a conversion. The software start bit clears itself when busy ends. After each run there is a short acquisition window in which new requests are ignored.

Top module: `adc_start_seq`

## Requirements
- R1: A rising edge on `startPin` while the block is idle sets `busy` and `holdCtl` to 1 after the next clock edge. `holdCtl` equals `busy` in every cycle.
- R2: When idle, a cycle with `busWr`=1 and `wrStartBit`=1 starts a run and sets `swStartBit` to 1. The bit reads 1 for the whole run.
- R3: A run begins at the first falling master-clock edge (the edge where `masterClk` is 1 just before it) that comes at least SETUP_CYC=2 edges after the request edge. When that setup is missed, the run begins at the next falling master-clock edge instead.
- R4: A conversion holds `busy` for CONV_HALVES=33 edges from its begin edge. From the request edge, this gives 35 cycles when `masterClk` read 1 at the request edge, and 36 cycles when it read 0.
- R5: A conversion ends with `convDone` high for exactly the first cycle in which `busy` is 0. `holdCtl` returns to 0 (track) in the same cycle.
- R6: `swStartBit` is 0 in the first cycle after `busy` falls.
- R7: The first run after reset is a calibration. `calActive` is high for the whole of that run. `busy` lasts CAL_HALVES=40 edges from the begin edge, and `convDone` is not pulsed. Later runs are conversions with `calActive` at 0.
- R8: Start requests on either path are ignored while `busy` is 1. A write made during a hardware-started run leaves `swStartBit` at 0.
- R9: Start requests are ignored during the ACQ_HALVES=3 cycles after `busy` falls.
- R10: `busWarn` is 1 in the cycle after a cycle that had a bus read or write while `busy` was 1. It is 0 after a bus access while idle.
- R11: After reset, `busy`, `holdCtl`, `calActive`, `convDone`, `swStartBit` and `busWarn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the master-clock rate |
| rstN | input | 1 | Synchronous active-low reset |
| startPin | input | 1 | Hardware start request, acts on its rising edge |
| busWr | input | 1 | Bus write strobe for the control register |
| busRd | input | 1 | Bus read strobe |
| wrStartBit | input | 1 | Start bit value carried by a write |
| masterClk | output | 1 | Generated master clock, toggles every cycle |
| busy | output | 1 | Run in progress |
| holdCtl | output | 1 | 1 = hold, 0 = track |
| calActive | output | 1 | Calibration run in progress |
| convDone | output | 1 | One-cycle strobe at the end of a conversion |
| swStartBit | output | 1 | Software start bit as stored |
| busWarn | output | 1 | Bus access happened during busy |

## Verification
Most faults in the internal state show up in the length of the busy pulse, and this length is visible within about 40 cycles of a request. A wrong setup margin or an off-by-one in the half-period counter changes the length by one or two cycles. The bench runs requests at both master-clock phases so that both setup outcomes are checked. A calibration flag that is stuck or cleared too early gives the wrong length or a wrong `convDone` on the first or second run. A request that should have been ignored shows up as a busy pulse that is too long, or as a new busy within the acquisition window.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CONV,
    ST_CAL,
    ST_ACQ
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic armSetup;  // start request accepted: restart setup counting
    logic loadRun;   // reload half-period counter (run begin or acquisition begin)
  } seqStrobe_t;
endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int CONV_HALVES = 33,
  parameter int CAL_HALVES  = 40,
  parameter int ACQ_HALVES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       mclkPhase,
  output logic       setupMet,
  output logic       convEnd,
  output logic       calEnd,
  output logic       acqEnd
);
  localparam int SW   = $clog2(SETUP_CYC + 1) + 1;
  localparam int MAX1 = (CONV_HALVES > CAL_HALVES) ? CONV_HALVES : CAL_HALVES;
  localparam int MAXH = (MAX1 > ACQ_HALVES) ? MAX1 : ACQ_HALVES;
  localparam int HW   = $clog2(MAXH + 1) + 1;

  logic [SW-1:0] setupCnt;
  logic [HW-1:0] halfCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mclkPhase <= 1'b0;
      setupCnt  <= '0;
      halfCnt   <= '0;
    end else begin
      mclkPhase <= ~mclkPhase;
      if (strobe.armSetup)
        setupCnt <= SW'(1);
      else if (setupCnt < SW'(SETUP_CYC))
        setupCnt <= setupCnt + SW'(1);
      if (strobe.loadRun)
        halfCnt <= HW'(1);
      else if (halfCnt != HW'(MAXH))
        halfCnt <= halfCnt + HW'(1);
    end
  end

  assign setupMet = (setupCnt >= SW'(SETUP_CYC));
  assign convEnd  = (halfCnt == HW'(CONV_HALVES));
  assign calEnd   = (halfCnt == HW'(CAL_HALVES));
  assign acqEnd   = (halfCnt == HW'(ACQ_HALVES));
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPin,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       wrStartBit,
  input  logic       mclkPhase,
  input  logic       setupMet,
  input  logic       convEnd,
  input  logic       calEnd,
  input  logic       acqEnd,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       calActive,
  output logic       convDone,
  output logic       swStartBit,
  output logic       busWarn
);
  seqState_t state;
  logic pinQ, calPending, calRun, missed;
  logic hwRise, swReq, request, beginNow;

  assign hwRise   = startPin & ~pinQ;
  assign swReq    = busWr & wrStartBit;
  assign request  = hwRise | swReq;
  assign busy     = (state == ST_WAIT) || (state == ST_CONV) || (state == ST_CAL);
  assign beginNow = (state == ST_WAIT) && mclkPhase && (setupMet || missed);

  always_comb begin
    strobe.armSetup = (state == ST_IDLE) && request;
    strobe.loadRun  = beginNow
                   || ((state == ST_CONV) && convEnd)
                   || ((state == ST_CAL) && calEnd);
  end

  assign calActive = calRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pinQ       <= 1'b0;
      calPending <= 1'b1;
      calRun     <= 1'b0;
      missed     <= 1'b0;
      swStartBit <= 1'b0;
      convDone   <= 1'b0;
      busWarn    <= 1'b0;
    end else begin
      pinQ     <= startPin;
      convDone <= 1'b0;
      busWarn  <= (busRd | busWr) & busy;
      unique case (state)
        ST_IDLE: if (request) begin
          state  <= ST_WAIT;
          missed <= 1'b0;
          calRun <= calPending;
          if (swReq) swStartBit <= 1'b1;
        end
        ST_WAIT: if (mclkPhase) begin
          if (setupMet || missed) state <= calRun ? ST_CAL : ST_CONV;
          else missed <= 1'b1;
        end
        ST_CONV: if (convEnd) begin
          state      <= ST_ACQ;
          convDone   <= 1'b1;
          swStartBit <= 1'b0;
        end
        ST_CAL: if (calEnd) begin
          state      <= ST_ACQ;
          calPending <= 1'b0;
          calRun     <= 1'b0;
          swStartBit <= 1'b0;
        end
        ST_ACQ: if (acqEnd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adcseq_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int CONV_HALVES = 33,
  parameter int CAL_HALVES  = 40,
  parameter int ACQ_HALVES  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPin,
  input  logic busWr,
  input  logic busRd,
  input  logic wrStartBit,
  output logic masterClk,
  output logic busy,
  output logic holdCtl,
  output logic calActive,
  output logic convDone,
  output logic swStartBit,
  output logic busWarn
);
  seqStrobe_t strobe;
  logic setupMet, convEnd, calEnd, acqEnd;

  adcseq_timer #(
    .SETUP_CYC(SETUP_CYC), .CONV_HALVES(CONV_HALVES),
    .CAL_HALVES(CAL_HALVES), .ACQ_HALVES(ACQ_HALVES)
  ) uTimer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mclkPhase(masterClk),
    .setupMet(setupMet), .convEnd(convEnd), .calEnd(calEnd), .acqEnd(acqEnd)
  );

  adcseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startPin(startPin), .busWr(busWr), .busRd(busRd),
    .wrStartBit(wrStartBit), .mclkPhase(masterClk), .setupMet(setupMet),
    .convEnd(convEnd), .calEnd(calEnd), .acqEnd(acqEnd), .strobe(strobe),
    .busy(busy), .calActive(calActive), .convDone(convDone),
    .swStartBit(swStartBit), .busWarn(busWarn)
  );

  assign holdCtl = busy;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic calActive,
  input logic convDone,
  input logic swStartBit,
  input logic busWarn
);
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!busy && $past(busy)));  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);  // R5
  AST_SW_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !swStartBit);  // R6
  AST_CAL_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    calActive |-> busy);  // R7
  AST_CAL_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(calActive)) |-> !convDone);  // R7
  AST_WARN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busWarn |-> $past(busy));  // R10
endmodule

bind adc_start_seq adcseq_checker uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .calActive(calActive),
  .convDone(convDone), .swStartBit(swStartBit), .busWarn(busWarn)
);

// File: tb/tb_adc_start_seq.sv
module tb_adc_start_seq;
  localparam int CONV = 33;
  localparam int CAL  = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic startPin = 1'b0, busWr = 1'b0, busRd = 1'b0, wrStartBit = 1'b0;
  logic masterClk, busy, holdCtl, calActive, convDone, swStartBit, busWarn;

  int checks = 0, fails = 0;
  bit finished = 0;
  int lenQ[$];
  bit calQ[$];

  always #10 clk = ~clk;

  adc_start_seq #(.SETUP_CYC(2), .CONV_HALVES(CONV), .CAL_HALVES(CAL), .ACQ_HALVES(3)) dut (
    .clk(clk), .rstN(rstN), .startPin(startPin), .busWr(busWr), .busRd(busRd),
    .wrStartBit(wrStartBit), .masterClk(masterClk), .busy(busy), .holdCtl(holdCtl),
    .calActive(calActive), .convDone(convDone), .swStartBit(swStartBit), .busWarn(busWarn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures each busy pulse and compares with the scoreboard
  int busyLen = 0;
  bit prevBusy = 0, calSeen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (holdCtl !== busy) check(0, "R1 hold==busy", holdCtl, busy);
      if (busy) begin
        busyLen++;
        calSeen |= calActive;
      end else if (prevBusy) begin
        if (lenQ.size() == 0) check(0, "R8 unexpected run", busyLen, 0);
        else begin
          automatic int expLen = lenQ.pop_front();
          automatic bit expCal = calQ.pop_front();
          check(busyLen == expLen, expCal ? "R7 cal length" : "R3/R4 conv length", busyLen, expLen);
          check(convDone == !expCal, "R5/R7 done strobe", convDone, !expCal);
          check(calSeen == expCal, "R7 calActive", calSeen, expCal);
          check(swStartBit == 0, "R6 sw bit cleared", swStartBit, 0);
          check(holdCtl == 0, "R5 back to track", holdCtl, 0);
        end
        busyLen = 0;
        calSeen = 0;
      end
      prevBusy = busy;
    end
  end

  // driver: one run, expected length pushed to the scoreboard
  task automatic doStart(input bit useSw, input bit wantPh, input bit isCal,
                         input bit midNoise, input bit acqProbe);
    bit p;
    @(negedge clk);
    while (masterClk !== wantPh) @(negedge clk);
    p = masterClk;
    lenQ.push_back((isCal ? CAL : CONV) + (p ? 2 : 3));
    calQ.push_back(isCal);
    if (useSw) begin busWr = 1; wrStartBit = 1; end
    else startPin = 1;
    @(negedge clk);
    busWr = 0; wrStartBit = 0; startPin = 0;
    check(busy && holdCtl, "R1 busy+hold after request", busy, 1);
    if (useSw) check(swStartBit == 1, "R2 sw bit set", swStartBit, 1);
    if (midNoise) begin
      repeat (5) @(negedge clk);
      startPin = 1; busWr = 1; wrStartBit = 1; busRd = 1;
      @(negedge clk);
      startPin = 0; busWr = 0; wrStartBit = 0; busRd = 0;
      check(busWarn == 1, "R10 warn during busy", busWarn, 1);
      check(swStartBit == useSw, "R8 write ignored during run", swStartBit, useSw);
    end
    while (busy) @(negedge clk);
    if (acqProbe) begin
      startPin = 1;
      @(negedge clk);
      startPin = 0;
      for (int i = 0; i < 6; i++) begin
        check(busy == 0, "R9 ignored in acquisition", busy, 0);
        @(negedge clk);
      end
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check({busy, holdCtl, calActive, convDone, swStartBit, busWarn} == 6'b0,
          "R11 reset state", {busy, holdCtl, calActive, convDone, swStartBit, busWarn}, 0);
    busRd = 1;
    @(negedge clk);
    busRd = 0;
    @(negedge clk);
    check(busWarn == 0, "R10 no warn when idle", busWarn, 0);
    doStart(0, 1, 1, 0, 0);  // R7 calibration first
    doStart(0, 1, 0, 0, 0);  // R3 R4 setup met
    doStart(0, 0, 0, 0, 0);  // R3 R4 setup missed
    doStart(1, 0, 0, 0, 0);  // R2 R6 software start
    doStart(1, 1, 0, 1, 0);  // R8 R10 noise during sw run
    doStart(0, 0, 0, 1, 0);  // R8 noise during hw run
    doStart(0, 1, 0, 0, 1);  // R9 acquisition window
    doStart(1, 1, 0, 0, 0);  // R9 start accepted afterwards
    repeat (5) @(negedge clk);
    check(lenQ.size() == 0, "R5 all runs completed", lenQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule